// File: doc/BRIEF.md
# I2C Descriptor Transfer Sequencer

This block turns one I2C transfer descriptor into an ordered series of byte-level commands for a separate byte engine, which handles SCL/SDA timing. The series can include START, address byte(s), data writes, data reads with an ACK or NACK choice, and STOP. A descriptor holds:

- a 16-bit target address, where bit 15 selects 10-bit addressing;
- a one-hot bus-condition field;
- a direction mode;
- two byte counts.

Data to be written arrives on a valid/ready byte stream. Bytes that are read leave on a second valid/ready stream. When the descriptor is finished, a single-cycle completion pulse carries a status code.

Start and end conditions are chosen per descriptor. A transaction can therefore be split over several descriptors: end one with HOLD and open the next with CONTINUE, and no condition appears between them. A read descriptor may carry a write prefix. When it does, the block places the repeated start and the read address on its own.

The byte engine takes one command at a time. `cmd_valid` is held until `cmd_ready`. Each accepted command is answered by exactly one `rsp_valid` pulse, which carries the ACK/NACK the engine received and, for reads, the received byte.

Top module: `i2c_desc_seq`

## Requirements
- R1: After reset, `desc_ready` is 1 and `cmd_valid`, `done`, `rd_valid` and `wr_ready` are 0. The bus counts as not held. A descriptor is taken only while `desc_ready` is high.
- R2: Bus-condition bits are: bit 0 START, bit 1 RESTART, bit 2 CONTINUE, bit 3 STOP, bit 4 HOLD. If there is not exactly one of bits 0..2 and exactly one of bits 3..4, the descriptor completes with status 1 (ERROR) and no command is issued.
- R3: Mode 1 is write and needs count0 ≥ 1. Mode 0 is read and needs count1 ≥ 1. A descriptor that breaks this rule completes with ERROR and no command is issued.
- R4: START and RESTART both issue command op START before the first address byte.
- R5: With address bit 15 clear, the address byte is {addr[6:0], R/W}. With bit 15 set, the first byte is {5'b11110, addr[9:8], R/W} and the second is addr[7:0]. R/W is 1 for a read.
- R6: In write mode, count0 bytes and then count1 bytes are taken from the write stream and sent as consecutive WRITE commands, with no condition between the two groups.
- R7: In read mode, count0 prefix bytes are written first. Then a START and one address byte with R/W=1 are issued. In 10-bit mode only the first address byte is resent. A 10-bit read without a prefix still sends both address bytes with R/W=0 before the restart. A 7-bit read without a prefix sends one address byte with R/W=1.
- R8: Each read command requests ACK (`cmd_nack`=0), except the last read of the descriptor, which requests NACK. Each received byte is offered on the read stream in order.
- R9: CONTINUE issues neither START nor address bytes. It is rejected with ERROR unless the last accepted descriptor ended with HOLD. STOP, a timeout or reset clears the held state.
- R10: With STOP as the end condition, the last command is op STOP. With HOLD, no condition follows the last byte.
- R11: A NACK on an address or write byte ends the descriptor with ERROR and skips the remaining bytes. A STOP is still issued if the end condition is STOP.
- R12: If the engine does not accept a command, or does not respond, within TIMEOUT_CYC cycles, the descriptor completes with status 2 (TIMEOUT) and no further command is issued.
- R13: Op codes are START=0, STOP=1, WRITE=2, READ=3. `cmd_byte` is 0 for all ops other than WRITE. Command fields stay stable while waiting for `cmd_ready`. `done` lasts one cycle and status 0 means OK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Sequencer idle, descriptor taken |
| desc_addr | input | 16 | Target address, bit 15 selects 10-bit |
| desc_cond | input | 5 | One-hot start/end conditions |
| desc_mode | input | 1 | 1 write, 0 read |
| desc_cnt0 | input | CW | First byte count |
| desc_cnt1 | input | CW | Second byte count |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| cmd_valid | output | 1 | Engine command valid |
| cmd_ready | input | 1 | Engine accepts command |
| cmd_op | output | 2 | Command op code |
| cmd_nack | output | 1 | Answer this read with NACK |
| cmd_byte | output | 8 | Byte to send |
| rsp_valid | input | 1 | Engine response |
| rsp_nack | input | 1 | Target answered NACK |
| rsp_byte | input | 8 | Received byte |
| done | output | 1 | Completion pulse |
| done_status | output | 2 | 0 OK, 1 ERROR, 2 TIMEOUT |

## Verification
The bench targets the following corner cases and the failure each would expose:
- **Restart placement:** a 7-bit read with a prefix, and a 10-bit read without one. A design that forgot the write phase of a 10-bit read would issue a single START followed by a read address.
- **Chaining:** CONTINUE after HOLD, and CONTINUE after a timeout or a reset has released the bus. A design that kept stale held state would issue bus traffic that should have been rejected.
- **NACK aborts:** aborts under STOP and under HOLD, which show whether a STOP still follows or whether extra data bytes leak out.
- **Stalled engine:** an engine that never accepts shows whether the sequencer hangs or completes with TIMEOUT.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_ERROR   = 2'd1,
        ST_TIMEOUT = 2'd2,
        ST_SKIPPED = 2'd3
    } done_code_e;

    // bit positions inside the condition field
    localparam int CB_START   = 0;
    localparam int CB_RESTART = 1;
    localparam int CB_CONT    = 2;
    localparam int CB_STOP    = 3;
    localparam int CB_HOLD    = 4;
    localparam int CB_WIDTH   = 5;

    typedef enum logic [3:0] {
        SP_START, SP_ADDR1, SP_ADDR2, SP_WRITE,
        SP_RSTART, SP_RADDR, SP_READ, SP_STOP, SP_FIN
    } step_e;

    typedef enum logic [2:0] {
        FS_IDLE, FS_ROUTE, FS_ISSUE, FS_WAIT, FS_FETCH, FS_RDOUT, FS_DONE
    } fsm_e;

    function automatic logic [7:0] addr_byte(input logic [15:0] a,
                                             input logic rnw,
                                             input logic second);
        if (!a[15])
            return {a[6:0], rnw};
        else if (second)
            return a[7:0];
        else
            return {5'b11110, a[9:8], rnw};
    endfunction

endpackage

// File: rtl/dseq_cond_check.sv
module dseq_cond_check
    import i2c_seq_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic [CB_WIDTH-1:0] cond,
    input  logic                mode,
    input  logic [CW-1:0]       cnt0,
    input  logic [CW-1:0]       cnt1,
    input  logic                held,
    output logic                ok
);
    logic starts_one, ends_one, counts_ok, cont_ok;

    always_comb begin
        starts_one = ($countones(cond[CB_CONT:CB_START]) == 1);
        ends_one   = ($countones(cond[CB_HOLD:CB_STOP]) == 1);
        counts_ok  = mode ? (cnt0 != '0) : (cnt1 != '0);
        cont_ok    = !cond[CB_CONT] || held;
        ok         = starts_one && ends_one && counts_ok && cont_ok;
    end
endmodule

// File: rtl/dseq_watchdog.sv
module dseq_watchdog #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic kick,
    output logic expired
);
    localparam int WW = $clog2(LIMIT + 1);
    localparam logic [WW-1:0] LAST = WW'(LIMIT - 1);

    logic [WW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || kick)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign expired = run && !kick && (cnt == LAST);

    AST_WD_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (!run || kick) |=> !expired || (LIMIT == 1)) else $error("wd"); // R12
endmodule

// File: rtl/i2c_desc_seq.sv
module i2c_desc_seq
    import i2c_seq_pkg::*;
#(
    parameter int CW          = 8,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                desc_valid,
    output logic                desc_ready,
    input  logic [15:0]         desc_addr,
    input  logic [CB_WIDTH-1:0] desc_cond,
    input  logic                desc_mode,
    input  logic [CW-1:0]       desc_cnt0,
    input  logic [CW-1:0]       desc_cnt1,
    input  logic                wr_valid,
    output logic                wr_ready,
    input  logic [7:0]          wr_data,
    output logic                rd_valid,
    input  logic                rd_ready,
    output logic [7:0]          rd_data,
    output logic                cmd_valid,
    input  logic                cmd_ready,
    output logic [1:0]          cmd_op,
    output logic                cmd_nack,
    output logic [7:0]          cmd_byte,
    input  logic                rsp_valid,
    input  logic                rsp_nack,
    input  logic [7:0]          rsp_byte,
    output logic                done,
    output logic [1:0]          done_status
);
    localparam int WLW = CW + 1;

    fsm_e        fsm;
    step_e       step_q, succ, rs_step;
    fsm_e        rs_fsm;
    done_code_e  status_q;
    logic [15:0] addr_q;
    logic        mode_q, stop_q, nrs_q, dir1_q, held_q;
    logic [WLW-1:0] wleft;
    logic [CW-1:0]  rleft;
    logic [7:0]  byte_q, rd_q;
    logic        desc_ok, wd_exp, wd_run, wd_kick, is_tx_step;
    bus_op_e     op_c;
    step_e       after_data;

    dseq_cond_check #(.CW(CW)) u_chk (
        .cond(desc_cond), .mode(desc_mode), .cnt0(desc_cnt0),
        .cnt1(desc_cnt1), .held(held_q), .ok(desc_ok)
    );

    assign wd_run  = (fsm == FS_ISSUE) || (fsm == FS_WAIT);
    assign wd_kick = (cmd_valid && cmd_ready) || rsp_valid;

    dseq_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wd (
        .clk(clk), .rst(rst), .run(wd_run), .kick(wd_kick), .expired(wd_exp)
    );

    // successor of the current step, then resolution into a state
    always_comb begin
        if (wleft != '0)      after_data = SP_WRITE;
        else if (nrs_q)       after_data = SP_RSTART;
        else if (!mode_q)     after_data = SP_READ;
        else                  after_data = SP_FIN;
        case (step_q)
            SP_START:  succ = SP_ADDR1;
            SP_ADDR1:  succ = addr_q[15] ? SP_ADDR2 : after_data;
            SP_ADDR2,
            SP_WRITE:  succ = after_data;
            SP_RSTART: succ = SP_RADDR;
            SP_RADDR:  succ = SP_READ;
            SP_READ:   succ = (rleft != '0) ? SP_READ : SP_FIN;
            default:   succ = SP_FIN;
        endcase
        rs_step = succ;
        rs_fsm  = FS_ISSUE;
        if (succ == SP_FIN) begin
            rs_step = stop_q ? SP_STOP : SP_FIN;
            rs_fsm  = stop_q ? FS_ISSUE : FS_DONE;
        end else if (succ == SP_WRITE) begin
            rs_fsm  = FS_FETCH;
        end
    end

    assign is_tx_step = (step_q == SP_ADDR1) || (step_q == SP_ADDR2) ||
                        (step_q == SP_WRITE) || (step_q == SP_RADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm      <= FS_IDLE;
            step_q   <= SP_START;
            status_q <= ST_OK;
            addr_q   <= '0;
            mode_q   <= 1'b0;
            stop_q   <= 1'b0;
            nrs_q    <= 1'b0;
            dir1_q   <= 1'b0;
            held_q   <= 1'b0;
            wleft    <= '0;
            rleft    <= '0;
            byte_q   <= '0;
            rd_q     <= '0;
        end else begin
            case (fsm)
                FS_IDLE: if (desc_valid) begin
                    status_q <= desc_ok ? ST_OK : ST_ERROR;
                    if (desc_ok) begin
                        addr_q <= desc_addr;
                        mode_q <= desc_mode;
                        stop_q <= desc_cond[CB_STOP];
                        held_q <= desc_cond[CB_HOLD];
                        nrs_q  <= !desc_mode && ((desc_cnt0 != '0) ||
                                  (desc_addr[15] && !desc_cond[CB_CONT]));
                        dir1_q <= !desc_mode && (desc_cnt0 == '0) && !desc_addr[15];
                        wleft  <= desc_mode ? ({1'b0, desc_cnt0} + {1'b0, desc_cnt1})
                                            : {1'b0, desc_cnt0};
                        rleft  <= desc_cnt1;
                        step_q <= desc_cond[CB_CONT] ? SP_ADDR2 : SP_START;
                        fsm    <= desc_cond[CB_CONT] ? FS_ROUTE : FS_ISSUE;
                    end else begin
                        fsm <= FS_DONE;
                    end
                end
                FS_ROUTE: begin
                    step_q <= rs_step;
                    fsm    <= rs_fsm;
                end
                FS_ISSUE: begin
                    if (wd_exp) begin
                        status_q <= ST_TIMEOUT;
                        held_q   <= 1'b0;
                        fsm      <= FS_DONE;
                    end else if (cmd_ready) begin
                        fsm <= FS_WAIT;
                    end
                end
                FS_WAIT: begin
                    if (wd_exp) begin
                        status_q <= ST_TIMEOUT;
                        held_q   <= 1'b0;
                        fsm      <= FS_DONE;
                    end else if (rsp_valid) begin
                        if (step_q == SP_STOP) begin
                            fsm <= FS_DONE;
                        end else if (step_q == SP_READ) begin
                            rd_q  <= rsp_byte;
                            rleft <= rleft - 1'b1;
                            fsm   <= FS_RDOUT;
                        end else if (rsp_nack && is_tx_step) begin
                            status_q <= ST_ERROR;
                            step_q   <= SP_STOP;
                            fsm      <= stop_q ? FS_ISSUE : FS_DONE;
                        end else begin
                            step_q <= rs_step;
                            fsm    <= rs_fsm;
                        end
                    end
                end
                FS_FETCH: if (wr_valid) begin
                    byte_q <= wr_data;
                    wleft  <= wleft - 1'b1;
                    fsm    <= FS_ISSUE;
                end
                FS_RDOUT: if (rd_ready) begin
                    step_q <= rs_step;
                    fsm    <= rs_fsm;
                end
                default: fsm <= FS_IDLE;
            endcase
        end
    end

    always_comb begin
        op_c     = OP_START;
        cmd_byte = 8'h00;
        cmd_nack = 1'b0;
        case (step_q)
            SP_STOP:  op_c = OP_STOP;
            SP_ADDR1: begin op_c = OP_WRITE; cmd_byte = addr_byte(addr_q, dir1_q, 1'b0); end
            SP_ADDR2: begin op_c = OP_WRITE; cmd_byte = addr_byte(addr_q, 1'b0, 1'b1); end
            SP_WRITE: begin op_c = OP_WRITE; cmd_byte = byte_q; end
            SP_RADDR: begin op_c = OP_WRITE; cmd_byte = addr_byte(addr_q, 1'b1, 1'b0); end
            SP_READ:  begin op_c = OP_READ;  cmd_nack = (rleft == CW'(1)); end
            default:  op_c = OP_START;
        endcase
    end

    assign cmd_valid   = (fsm == FS_ISSUE);
    assign cmd_op      = op_c;
    assign desc_ready  = (fsm == FS_IDLE);
    assign wr_ready    = (fsm == FS_FETCH);
    assign rd_valid    = (fsm == FS_RDOUT);
    assign rd_data     = rd_q;
    assign done        = (fsm == FS_DONE);
    assign done_status = status_q;

    AST_CMD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte))
                                      || (done && done_status == ST_TIMEOUT)) else $error("stable"); // R13
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("pulse"); // R13
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && desc_ready && !desc_ok) |=> (done && done_status == ST_ERROR && !cmd_valid)) else $error("reject"); // R2
    AST_FETCH_EXCL: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> (!cmd_valid && !rd_valid)) else $error("fetch"); // R6
    AST_TIMEOUT_END: assert property (@(posedge clk) disable iff (rst)
        wd_exp |=> (done && done_status == ST_TIMEOUT)) else $error("timeout"); // R12
    AST_ABORT_STOP: assert property (@(posedge clk) disable iff (rst)
        (fsm == FS_WAIT && rsp_valid && rsp_nack && is_tx_step && stop_q && !wd_exp)
            |=> (cmd_valid && cmd_op == OP_STOP)) else $error("abort"); // R11
endmodule

// File: tb/sim_i2c_desc_seq.sv
`timescale 1ns/1ps
module sim_i2c_desc_seq;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst;
    logic desc_valid, desc_ready, desc_mode;
    logic [15:0] desc_addr;
    logic [4:0] desc_cond;
    logic [7:0] desc_cnt0, desc_cnt1;
    logic wr_valid, wr_ready, rd_valid, rd_ready;
    logic [7:0] wr_data, rd_data;
    logic cmd_valid, cmd_ready, cmd_nack, rsp_valid, rsp_nack, done;
    logic [1:0] cmd_op, done_status;
    logic [7:0] cmd_byte, rsp_byte;

    i2c_desc_seq u0 (
        .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_addr(desc_addr), .desc_cond(desc_cond), .desc_mode(desc_mode),
        .desc_cnt0(desc_cnt0), .desc_cnt1(desc_cnt1), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_data(rd_data), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_nack(cmd_nack),
        .cmd_byte(cmd_byte), .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
        .rsp_byte(rsp_byte), .done(done), .done_status(done_status)
    );

    typedef struct packed {
        logic [15:0] a; logic [4:0] c; logic m;
        logic [7:0] n0; logic [7:0] n1; logic [4:0] nk; logic stall; logic [1:0] st;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VT [NV] = '{
        '{16'h0050, 5'b01001, 1'b1, 8'd2, 8'd1, 5'd31, 1'b0, 2'd0}, // R6 plain write
        '{16'h0021, 5'b01001, 1'b0, 8'd1, 8'd3, 5'd31, 1'b0, 2'd0}, // R7 prefix+restart
        '{16'h0021, 5'b01001, 1'b0, 8'd0, 8'd2, 5'd31, 1'b0, 2'd0}, // R8 read only
        '{16'h82A5, 5'b10001, 1'b1, 8'd1, 8'd0, 5'd31, 1'b0, 2'd0}, // R5 10-bit hold
        '{16'h82A5, 5'b01100, 1'b1, 8'd1, 8'd2, 5'd31, 1'b0, 2'd0}, // R9 continue
        '{16'h81C3, 5'b01010, 1'b0, 8'd0, 8'd1, 5'd31, 1'b0, 2'd0}, // R4 restart 10-bit read
        '{16'h0050, 5'b01100, 1'b1, 8'd1, 8'd0, 5'd31, 1'b0, 2'd1}, // R9 cont not held
        '{16'h0050, 5'b01011, 1'b1, 8'd1, 8'd0, 5'd31, 1'b0, 2'd1}, // R2 two starts
        '{16'h0050, 5'b00001, 1'b1, 8'd1, 8'd0, 5'd31, 1'b0, 2'd1}, // R2 no end
        '{16'h0050, 5'b01001, 1'b1, 8'd0, 8'd3, 5'd31, 1'b0, 2'd1}, // R3 write cnt0=0
        '{16'h0050, 5'b01001, 1'b0, 8'd2, 8'd0, 5'd31, 1'b0, 2'd1}, // R3 read cnt1=0
        '{16'h0050, 5'b01001, 1'b1, 8'd2, 8'd0, 5'd2,  1'b0, 2'd1}, // R11 nack on data
        '{16'h0033, 5'b10001, 1'b0, 8'd1, 8'd1, 5'd1,  1'b0, 2'd1}, // R11 nack addr hold
        '{16'h0033, 5'b01100, 1'b0, 8'd0, 8'd2, 5'd31, 1'b0, 2'd0}, // R10 continue read
        '{16'h0050, 5'b10001, 1'b1, 8'd1, 8'd0, 5'd31, 1'b1, 2'd2}, // R12 stall
        '{16'h0050, 5'b01100, 1'b1, 8'd1, 8'd0, 5'd31, 1'b0, 2'd1}, // R9 after timeout
        '{16'h0050, 5'b10001, 1'b1, 8'd1, 8'd0, 5'd31, 1'b0, 2'd0}  // R10 hold before reset
    };

    int nchk = 0, nfail = 0;
    bit finished = 0;
    logic [10:0] got [32];
    logic [10:0] expt [32];
    logic [7:0]  rdl [16];
    int glen, elen, nrd, rlen, wk;
    bit took, cur_stall;
    logic [4:0] cur_nk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ab(input logic [15:0] a, input logic rnw, input logic sec);
        if (!a[15]) return {a[6:0], rnw};
        if (sec) return a[7:0];
        return {5'b11110, a[9:8], rnw};
    endfunction

    task automatic push(input logic [1:0] op, input logic nk, input logic [7:0] b);
        if (elen < 32) expt[elen] = {op, nk, b};
        elen++;
    endtask

    task automatic build(input vec_t v);
        bit cont, ten, rd, nrs;
        int wt;
        elen = 0;
        if (v.stall || (v.st == 2'd1 && v.nk == 5'd31)) return;
        cont = v.c[2]; ten = v.a[15]; rd = !v.m;
        nrs = rd && (v.n0 != 0 || (ten && !cont));
        wt = rd ? int'(v.n0) : int'(v.n0) + int'(v.n1);
        if (!cont) begin
            push(2'd0, 1'b0, 8'h00);
            push(2'd2, 1'b0, ab(v.a, rd && !nrs, 1'b0));
            if (ten) push(2'd2, 1'b0, ab(v.a, 1'b0, 1'b1));
        end
        for (int k = 0; k < wt; k++) push(2'd2, 1'b0, 8'h30 + 8'(k));
        if (nrs) begin
            push(2'd0, 1'b0, 8'h00);
            push(2'd2, 1'b0, ab(v.a, 1'b1, 1'b0));
        end
        if (rd) for (int k = 0; k < int'(v.n1); k++) push(2'd3, (k == int'(v.n1) - 1), 8'h00);
        if (v.nk != 5'd31) elen = int'(v.nk) + 1;
        if (v.c[3]) push(2'd1, 1'b0, 8'h00);
    endtask

    // byte engine model
    initial begin
        cmd_ready = 0; rsp_valid = 0; rsp_nack = 0; rsp_byte = 0;
        forever begin
            @(negedge clk);
            rsp_valid = 0; rsp_nack = 0;
            if (cmd_valid && !cur_stall && !rst) begin
                bit hit, isrd;
                if (glen < 32) got[glen] = {cmd_op, cmd_nack, cmd_byte};
                hit = (glen == int'(cur_nk));
                isrd = (cmd_op == 2'd3);
                glen++;
                cmd_ready = 1;
                @(negedge clk);
                cmd_ready = 0; rsp_valid = 1; rsp_nack = hit;
                rsp_byte = isrd ? 8'hC0 + 8'(nrd) : 8'h00;
                if (isrd) nrd++;
            end
        end
    end

    // write source and read sink
    initial begin
        wr_valid = 1; wr_data = 8'h30; took = 0; rd_ready = 1;
        forever begin
            @(negedge clk);
            if (took) wk++;
            wr_data = 8'h30 + 8'(wk);
            took = wr_ready;
            if (rd_valid) begin
                if (rlen < 16) rdl[rlen] = rd_data;
                rlen++;
            end
        end
    end

    task automatic run_desc(input vec_t v, output logic [1:0] st);
        cur_stall = v.stall; cur_nk = v.nk;
        glen = 0; nrd = 0; wk = 0; rlen = 0; took = 0;
        desc_addr = v.a; desc_cond = v.c; desc_mode = v.m;
        desc_cnt0 = v.n0; desc_cnt1 = v.n1; desc_valid = 1;
        @(negedge clk);
        desc_valid = 0;
        while (!done) @(negedge clk);
        st = done_status;
        @(negedge clk);
    endtask

    task automatic check_vec(input vec_t v, input int i);
        logic [1:0] st;
        bit ok;
        int erd;
        run_desc(v, st);
        chk(st == v.st, $sformatf("R2/R3/R11/R12 status v%0d", i), st, v.st);
        build(v);
        ok = (glen == elen);
        for (int k = 0; k < elen && k < 32; k++) if (ok && got[k] !== expt[k]) ok = 0;
        chk(ok, $sformatf("R4-R10 trace v%0d (len)", i), glen, elen);
        erd = (v.st == 2'd0 && !v.m) ? int'(v.n1) : 0;
        ok = (rlen == erd);
        for (int k = 0; k < erd && k < 16; k++) if (ok && rdl[k] !== 8'hC0 + 8'(k)) ok = 0;
        chk(ok, $sformatf("R8 read stream v%0d (len)", i), rlen, erd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nfail++; nchk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [1:0] st;
        vec_t cv;
        cur_stall = 0; cur_nk = 5'd31; glen = 0; nrd = 0; rlen = 0; wk = 0;
        desc_valid = 0; desc_addr = 0; desc_cond = 0; desc_mode = 0;
        desc_cnt0 = 0; desc_cnt1 = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(desc_ready == 1'b1, "R1 desc_ready", desc_ready, 1);
        chk(cmd_valid == 1'b0 && done == 1'b0, "R1 cmd_valid/done", {cmd_valid, done}, 0);
        chk(rd_valid == 1'b0 && wr_ready == 1'b0, "R1 rd_valid/wr_ready", {rd_valid, wr_ready}, 0);

        for (int i = 0; i < NV; i++) check_vec(VT[i], i);

        // R1 R9: reset releases a held bus
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(desc_ready == 1'b1 && cmd_valid == 1'b0, "R1 after reset", {desc_ready, cmd_valid}, 2);
        cv = '{16'h0050, 5'b01100, 1'b1, 8'd1, 8'd0, 5'd31, 1'b0, 2'd1};
        run_desc(cv, st);
        chk(st == 2'd1, "R9 continue after reset rejected", st, 1);
        chk(glen == 0, "R9 no commands after reject", glen, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule